// File: doc/BRIEF.md
# Asynchronous Sleep Mode Controller

This block sequences a synchronous design into and out of a low-power sleep state on request from a pin that has no timing relation to the clock. The request passes through a flop chain before any decision is taken on it. Entry and exit each spend a fixed number of clock cycles in a transition state. After exit, a recovery window follows in which the chip-select lines must stay idle.

Entry does not begin while any chip select is active, so the block is always deselected when it starts going to sleep. From the first entry cycle until recovery ends, an inhibit output stops new accesses from being issued. Any access still pending when entry begins is treated as invalid. A select seen during the recovery window raises a violation flag that stays set until reset.

Top module: `sleep_ctl`

## Requirements
- R1: During and right after reset, `inhibit_o`, `sleep_o` and `recov_viol_o` are all 0.
- R2: The sleep request passes through a two-flop synchroniser. When `sleep_req_i` is raised while the block is awake and deselected, `inhibit_o` stays 0 after the second rising edge and is 1 after the third.
- R3: Entry lasts two cycles. `sleep_o` becomes 1 two rising edges after `inhibit_o` becomes 1.
- R4: While any bit of `cs_active_i` is 1 (active high), entry is held off and `inhibit_o` stays 0. Entry starts at the first rising edge at which all selects are 0 and the synchronised request is 1.
- R5: While the request stays high, the block stays asleep with `sleep_o` = 1 and `inhibit_o` = 1. `inhibit_o` is 1 in every state except awake.
- R6: When `sleep_req_i` is dropped, `sleep_o` falls after the third rising edge. Exit lasts two cycles and recovery lasts two more. `inhibit_o` stays 1 through both and returns to 0 after the seventh rising edge.
- R7: If any select is active at a rising edge during the recovery window, `recov_viol_o` is 1 from that edge on and stays 1 until reset.
- R8: Select activity while asleep or exiting does not set `recov_viol_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Sleep request, asynchronous to the clock, active high |
| cs_active_i | input | CS_W | Chip-select activity, one bit per select, active high |
| sleep_o | output | 1 | High while in the asleep state |
| inhibit_o | output | 1 | High whenever the block is not awake; blocks access issue |
| recov_viol_o | output | 1 | Sticky flag for select activity during recovery |

## Verification
A change on the request input reaches the state machine after two synchroniser edges, so `inhibit_o` responds on the third edge after the input is driven. `sleep_o` follows two edges after that. On exit, `sleep_o` falls on the third edge and `inhibit_o` falls on the seventh. Select inputs are sampled directly, so a held-off entry starts one edge after the selects clear, and a violation flag is set one edge after a select is seen in recovery. Inputs change on falling edges. Outputs are sampled one nanosecond after the rising edge at which each value is due, and the bench also checks the edge before, so a design that responds one cycle early fails.

// File: rtl/sleep_ctl_pkg.sv
package sleep_ctl_pkg;
  typedef enum logic [2:0] {
    ST_AWAKE    = 3'd0,
    ST_ENTERING = 3'd1,
    ST_ASLEEP   = 3'd2,
    ST_EXITING  = 3'd3,
    ST_RECOVER  = 3'd4
  } slp_state_e;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_ctl_pkg::*;
#(
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       cs_any_i,
  output slp_state_e state_o
);
  localparam int MAX_CYC = (ENTER_CYC > EXIT_CYC) ?
                           ((ENTER_CYC > RECOV_CYC) ? ENTER_CYC : RECOV_CYC) :
                           ((EXIT_CYC > RECOV_CYC) ? EXIT_CYC : RECOV_CYC);
  localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ENTER_LD = CNT_W'(ENTER_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LD  = CNT_W'(EXIT_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);

  slp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_AWAKE: if (req_i && !cs_any_i) begin
        state_d = ST_ENTERING;
        cnt_d   = ENTER_LD;
      end
      ST_ENTERING: begin
        if (cnt_zero) state_d = ST_ASLEEP;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_ASLEEP: if (!req_i) begin
        state_d = ST_EXITING;
        cnt_d   = EXIT_LD;
      end
      ST_EXITING: begin
        if (cnt_zero) begin
          state_d = ST_RECOVER;
          cnt_d   = RECOV_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cnt_zero) state_d = ST_AWAKE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/recov_mon.sv
module recov_mon
  import sleep_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  slp_state_e state_i,
  input  logic       cs_any_i,
  output logic       viol_o
);
  logic viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 viol_q <= 1'b0;
    else if (state_i == ST_RECOVER && cs_any_i)  viol_q <= 1'b1;
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
  import sleep_ctl_pkg::*;
#(
  parameter int CS_W        = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ENTER_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int RECOV_CYC   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sleep_req_i,
  input  logic [CS_W-1:0] cs_active_i,
  output logic            sleep_o,
  output logic            inhibit_o,
  output logic            recov_viol_o
);
  logic       req_s;
  logic       cs_any;
  slp_state_e state_w;

  assign cs_any = |cs_active_i;

  sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sleep_req_i),
    .sync_o (req_s)
  );

  sleep_fsm #(
    .ENTER_CYC(ENTER_CYC),
    .EXIT_CYC (EXIT_CYC),
    .RECOV_CYC(RECOV_CYC)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_s),
    .cs_any_i(cs_any),
    .state_o (state_w)
  );

  recov_mon u_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state_w),
    .cs_any_i(cs_any),
    .viol_o  (recov_viol_o)
  );

  assign sleep_o   = (state_w == ST_ASLEEP);
  assign inhibit_o = (state_w != ST_AWAKE);
endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk
  import sleep_ctl_pkg::*;
#(
  parameter int CS_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [CS_W-1:0] cs_active_i,
  input logic            sleep_o,
  input logic            inhibit_o,
  input logic            recov_viol_o,
  input slp_state_e      state_w
);
  // R5
  asleep_inhibits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> inhibit_o);

  // R3
  entry_precedes_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(inhibit_o) && !$past(sleep_o));

  // R4
  selected_no_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inhibit_o && (|cs_active_i)) |=> !inhibit_o);

  // R6
  exit_keeps_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> inhibit_o);

  // R7
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov_viol_o |=> recov_viol_o);

  // R8
  viol_only_recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!recov_viol_o && state_w != ST_RECOVER) |=> !recov_viol_o);
endmodule

bind sleep_ctl sleep_ctl_chk #(.CS_W(CS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_active_i (cs_active_i),
  .sleep_o     (sleep_o),
  .inhibit_o   (inhibit_o),
  .recov_viol_o(recov_viol_o),
  .state_w     (state_w)
);

// File: tb/sleep_ctl_tb.sv
`timescale 1ns/1ps
module sleep_ctl_tb;
  localparam int CS_W = 3;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            sleep_req_i = 1'b0;
  logic [CS_W-1:0] cs_active_i = '0;
  logic            sleep_o, inhibit_o, recov_viol_o;
  int              n_chk = 0;
  int              n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  sleep_ctl #(.CS_W(CS_W)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .cs_active_i (cs_active_i),
    .sleep_o     (sleep_o),
    .inhibit_o   (inhibit_o),
    .recov_viol_o(recov_viol_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; sleep_req_i = 1'b0; cs_active_i = '0;
    step(2);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic go_asleep();
    @(negedge clk_i);
    sleep_req_i = 1'b1;
    step(8);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 inhibit in reset", inhibit_o, 1'b0);
    check("R1 sleep in reset", sleep_o, 1'b0);
    check("R1 viol in reset", recov_viol_o, 1'b0);
    do_reset();
    check("R1 inhibit after reset", inhibit_o, 1'b0);
  endtask

  task automatic t_entry();
    do_reset();
    @(negedge clk_i);
    sleep_req_i = 1'b1;
    step(2);
    check("R2 inhibit after edge 2", inhibit_o, 1'b0);
    step(1);
    check("R2 inhibit after edge 3", inhibit_o, 1'b1);
    check("R3 sleep after edge 3", sleep_o, 1'b0);
    step(1);
    check("R3 sleep after edge 4", sleep_o, 1'b0);
    step(1);
    check("R3 sleep after edge 5", sleep_o, 1'b1);
    step(10);
    check("R5 sleep held", sleep_o, 1'b1);
    check("R5 inhibit held", inhibit_o, 1'b1);
  endtask

  task automatic t_exit();
    do_reset();
    go_asleep();
    @(negedge clk_i);
    sleep_req_i = 1'b0;
    step(2);
    check("R6 sleep after edge 2", sleep_o, 1'b1);
    step(1);
    check("R6 sleep after edge 3", sleep_o, 1'b0);
    check("R6 inhibit after edge 3", inhibit_o, 1'b1);
    for (int i = 4; i <= 6; i++) begin
      step(1);
      check("R6 inhibit in exit or recovery", inhibit_o, 1'b1);
    end
    step(1);
    check("R6 inhibit after edge 7", inhibit_o, 1'b0);
    check("R7 no viol without selects", recov_viol_o, 1'b0);
  endtask

  task automatic t_deselect();
    do_reset();
    @(negedge clk_i);
    cs_active_i = 3'b010;
    sleep_req_i = 1'b1;
    step(6);
    check("R4 held off while selected", inhibit_o, 1'b0);
    @(negedge clk_i);
    cs_active_i = 3'b000;
    step(1);
    check("R4 entry after select clears", inhibit_o, 1'b1);
    step(2);
    check("R4 asleep after deferred entry", sleep_o, 1'b1);
  endtask

  task automatic t_recov_viol();
    do_reset();
    go_asleep();
    @(negedge clk_i);
    sleep_req_i = 1'b0;
    step(5);
    check("R7 no viol before select", recov_viol_o, 1'b0);
    @(negedge clk_i);
    cs_active_i = 3'b100;
    step(1);
    check("R7 viol set in recovery", recov_viol_o, 1'b1);
    @(negedge clk_i);
    cs_active_i = 3'b000;
    step(6);
    check("R7 viol sticky", recov_viol_o, 1'b1);
    check("R7 awake after recovery", inhibit_o, 1'b0);
  endtask

  task automatic t_no_viol();
    do_reset();
    go_asleep();
    @(negedge clk_i);
    cs_active_i = 3'b001;
    step(3);
    check("R8 no viol while asleep", recov_viol_o, 1'b0);
    check("R8 still asleep", sleep_o, 1'b1);
    @(negedge clk_i);
    sleep_req_i = 1'b0;
    step(3);
    check("R8 no viol at exit start", recov_viol_o, 1'b0);
    @(negedge clk_i);
    cs_active_i = 3'b000;
    step(6);
    check("R8 no viol after clean recovery", recov_viol_o, 1'b0);
    check("R8 awake", inhibit_o, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_entry();
        t_exit();
        t_deselect();
        t_recov_viol();
        t_no_viol();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule